// File: doc/BRIEF.md
# Twin-Model Consecutive-Ones Detector

This block watches a single-bit serial stream and flags every clock in which the stream carries a run of at least two 1s. It holds two independent finite state machines fed from the same input. One is an input-dependent (Mealy) machine: its flag is a function of its stored state and the present input, so it rises in the same cycle as the second 1. The other is a state-only (Moore) machine: its flag is decoded from the stored state alone, so it rises one clock later and does not react to input changes within a cycle.

The block suits designs that need both a low-latency combinational hit and a glitch-free registered hit on the same stream. It also suits the comparison of the two machine styles on identical traffic. Reset is synchronous and active low.

Top module: `ones_run_detect`

## Requirements
- R1: In the first cycle after a clock edge sampled with `rst_n` low, `y_mealy` and `y_moore` are both 0, whatever the value of `x`.
- R2: A 1 on `x` that follows a 0, or that follows a reset, gives `y_mealy` = 0 in that cycle.
- R3: When `x` is 1 in the present cycle and was 1 at the previous clock edge (with no reset at that edge), `y_mealy` is 1 in the present cycle.
- R4: Whenever `x` is 0, `y_mealy` is 0 in the same cycle.
- R5: When `x` was sampled 1 at each of the last two clock edges (with no reset at either), `y_moore` is 1. It stays 1 for as long as further 1s are sampled.
- R6: When `x` was sampled 0 at the last clock edge, `y_moore` is 0. The state-only machine uses a 2-bit code: 00 idle, 01 one seen, 10 run. Code 11 is never reached, and if it were present it would lead to idle.
- R7: `y_moore` does not change when `x` changes between clock edges.
- R8: For any input stream with no reset involved, `y_moore` in cycle t+1 equals `y_mealy` in cycle t.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low; both machines go to idle |
| x | input | 1 | Serial data bit, sampled each rising edge |
| y_mealy | output | 1 | Run flag from the input-dependent machine, same-cycle |
| y_moore | output | 1 | Run flag from the state-only machine, one cycle later |

## Verification
The block has no parameters, so the bench builds it in its only configuration. In that configuration every state of both machines, and every arc between them, is reachable from the ports. A seeded random stream is used whose density of 1s is switched between sparse, even and dense. This produces isolated 1s, pairs and long runs, and each one is compared cycle by cycle against a bench-side model. Directed sequences add a reset in the middle of a run and a 1 directly after a reset. In every cycle the bench also toggles `x` before the edge, which shows that the Moore flag holds still while the Mealy flag follows the input.

// File: rtl/ones_run_pkg.sv
// Shared encodings for the twin-model consecutive-ones detector.
// Assumes: the state-only machine uses a 2-bit binary code, and code 11 is unused.
package ones_run_pkg;

    localparam int MOORE_W = 2;

    typedef enum logic {
        ML_IDLE  = 1'b0,
        ML_ARMED = 1'b1
    } mealy_st_e;

    typedef enum logic [MOORE_W-1:0] {
        MR_IDLE = 2'b00,
        MR_ONE  = 2'b01,
        MR_RUN  = 2'b10
    } moore_st_e;

endpackage

// File: rtl/ones_mealy_fsm.sv
// Two-state input-dependent detector: the flag is raised on the arc taken
// when a 1 arrives while the previous sampled bit was also 1.
// Assumes: synchronous active-low reset; x is stable around the rising edge.
module ones_mealy_fsm
    import ones_run_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic x,
    output logic y
);

    mealy_st_e st_q, st_d;

    // Next-state choice: any 1 arms the machine, any 0 disarms it.
    always_comb begin
        st_d = x ? ML_ARMED : ML_IDLE;
    end

    // State register with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ML_IDLE;
        else        st_q <= st_d;
    end

    // Arc output: asserted only when armed and the present bit is 1.
    always_comb begin
        y = (st_q == ML_ARMED) && x;
    end

    // R1: the cycle after a reset edge shows no hit.
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !y);

    // R3: two sampled 1s in a row give a same-cycle hit.
    p_pair_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (x && $past(x) && $past(rst_n)) |-> y);

    // R4: a present 0 never produces a hit.
    p_zero_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !x |-> !y);

    // R2: a 1 after a sampled 0 is not a hit.
    p_first_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (x && !$past(x)) |-> !y);

endmodule

// File: rtl/ones_moore_fsm.sv
// Three-state state-only detector: idle -> one seen -> run on consecutive 1s,
// with the flag decoded from the run state alone.
// Assumes: synchronous active-low reset; the unused code 11 leads to idle.
module ones_moore_fsm
    import ones_run_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic x,
    output logic y
);

    moore_st_e st_q, st_d;

    // Next-state choice: climb on 1s and saturate in run; drop to idle on 0.
    always_comb begin
        st_d = MR_IDLE;
        if (x) begin
            case (st_q)
                MR_IDLE: st_d = MR_ONE;
                MR_ONE:  st_d = MR_RUN;
                MR_RUN:  st_d = MR_RUN;
                default: st_d = MR_IDLE;
            endcase
        end
    end

    // State register with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= MR_IDLE;
        else        st_q <= st_d;
    end

    // State decode: the flag is high only in the run state.
    always_comb begin
        y = (st_q == MR_RUN);
    end

    // R1: the cycle after a reset edge the flag is low.
    p_reset_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !y);

    // R5: two sampled 1s give a raised flag.
    p_run_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(x) && $past(x, 2)) |-> y);

    // R6: a sampled 0 clears the flag.
    p_zero_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(x)) |-> !y);

    // R6: the unused code is never entered.
    p_code_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q != 2'b11);

endmodule

// File: rtl/ones_run_detect.sv
// Top: feeds one serial input to both detector styles side by side.
// Assumes: synchronous active-low reset shared by both machines.
module ones_run_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic x,
    output logic y_mealy,
    output logic y_moore
);

    ones_mealy_fsm u_mealy (
        .clk   (clk),
        .rst_n (rst_n),
        .x     (x),
        .y     (y_mealy)
    );

    ones_moore_fsm u_moore (
        .clk   (clk),
        .rst_n (rst_n),
        .x     (x),
        .y     (y_moore)
    );

    // R8: the state-only flag repeats the input-dependent flag one cycle later.
    p_skew_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (y_moore == $past(y_mealy)));

endmodule

// File: tb/ones_run_detect_bench.sv
// Self-checking bench: directed corners plus seeded random streams,
// compared against a bench-side model of both machines.
module ones_run_detect_bench;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic x = 1'b0;
    logic y_mealy, y_moore;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench-side model state.
    bit ref_seen = 1'b0;
    int ref_cnt = 0;
    bit ref_after_rst = 1'b0;
    bit prev_mealy = 1'b0;
    bit prev_valid = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ones_run_detect u_ones_run_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .x       (x),
        .y_mealy (y_mealy),
        .y_moore (y_moore)
    );

    function automatic bit exp_mealy(bit seen, bit xv);
        return seen & xv;
    endfunction

    function automatic bit exp_moore(int cnt);
        return (cnt >= 2);
    endfunction

    task automatic check(input bit act, input bit exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive at the falling edge, check, wiggle x, then update the model at the rising edge.
    task automatic step(input bit xv, input bit rv);
        bit moore_now;
        @(negedge clk);
        rst_n = rv;
        x = xv;
        #1;
        if (rv) begin
            if (ref_after_rst) begin
                check(y_mealy, 1'b0, "R1");
                check(y_moore, 1'b0, "R1");
            end
            if (!xv)            check(y_mealy, 1'b0, "R4");
            else if (!ref_seen) check(y_mealy, 1'b0, "R2");
            else                check(y_mealy, 1'b1, "R3");
            check(y_moore, exp_moore(ref_cnt), exp_moore(ref_cnt) ? "R5" : "R6");
            if (prev_valid) check(y_moore, prev_mealy, "R8");
            moore_now = y_moore;
            x = ~xv;
            #1;
            check(y_moore, moore_now, "R7");
            check(y_mealy, exp_mealy(ref_seen, ~xv), "R7");
            x = xv;
            #1;
        end
        prev_mealy = y_mealy;
        prev_valid = rv;
        @(posedge clk);
        if (!rv) begin
            ref_seen = 1'b0;
            ref_cnt = 0;
            ref_after_rst = 1'b1;
        end else begin
            ref_seen = xv;
            ref_cnt = xv ? ((ref_cnt < 2) ? ref_cnt + 1 : 2) : 0;
            ref_after_rst = 1'b0;
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // Reset held with x high; the first cycle after it must be quiet (R1, R2).
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        step(1'b0, 1'b1);
        // Isolated ones, then pairs, then a long run.
        step(1'b1, 1'b1); step(1'b0, 1'b1); step(1'b1, 1'b1); step(1'b1, 1'b1);
        step(1'b0, 1'b1); step(1'b0, 1'b1);
        for (int i = 0; i < 8; i++) step(1'b1, 1'b1);
        // Reset in the middle of a run (R1).
        step(1'b1, 1'b0);
        step(1'b1, 1'b1); step(1'b1, 1'b1); step(1'b1, 1'b1);
        // Random streams at three densities of ones.
        for (int phase = 0; phase < 3; phase++) begin
            for (int i = 0; i < 1500; i++) begin
                int r;
                r = int'($urandom_range(99, 0));
                case (phase)
                    0: step(r < 20, 1'b1);
                    1: step(r < 50, 1'b1);
                    default: step(r < 85, 1'b1);
                endcase
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule